// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block is an APB3 slave that gives a narrow bus window into two internal register spaces. It does not map those spaces directly. Each space has its own channel, and each channel offers three bus words: an address port, a data port and a control port. Software loads a 16-bit internal address into the address port and then moves words through the data port. The two channels have the same layout. Channel 0 sits at offsets 0x00 to 0x08 and channel 1 at 0x10 to 0x18.

Two rules give the block its character. First, an internal address only takes effect when software writes it twice in a row. Second, reads go through a one-word prefetch register. A data-port read returns whatever the prefetch register holds and then refills it from the confirmed address. Software therefore reads the data port twice and keeps the second value. Each channel also has an error-enable bit that lets a bad data access finish with PSLVERR. Small internal register files stand in for the real register spaces.

The bus side is plain APB3 with no back-pressure. PREADY is tied high, so every access completes in its access phase. Read data and PSLVERR are valid during that phase.

Top module: `indirect_reg_bridge`

## Requirements
- R1: Bus offsets are decoded from PADDR[4] (channel) and PADDR[3:2] (0 address port, 1 data port, 2 control port). Offset 0x0C, 0x1C and any offset with PADDR bits above bit 4 set read as zero, ignore writes and never raise PSLVERR. PREADY is always high.
- R2: A write to an address port keeps only PWDATA[15:0]. A read of the address port returns that staged value in bits 15:0, with zeros above.
- R3: A channel's internal address becomes confirmed only when two address-port writes with equal low 16 bits arrive with no access to that channel's data or control port between them. An address write whose value differs from the staged one leaves the address unconfirmed.
- R4: A data-port read returns the channel's prefetch register. In the same access, the prefetch register is reloaded with the word at the confirmed address. The second of two back-to-back data reads therefore returns the addressed word.
- R5: Any address-port write clears that channel's prefetch register to zero, so the next data read returns zero.
- R6: A single data-port write stores PWDATA at the confirmed internal address.
- R7: A data access is bad when the address is unconfirmed or is 16 or above (the register file depth). A bad write is dropped, and a bad read reloads the prefetch register with zero.
- R8: Control-port bit 15 enables error signalling. A bad data access raises PSLVERR only when this bit is set. A control read returns only bit 15, with all other bits zero.
- R9: The two channels have separate address, prefetch, control and register-file state. An access to one channel leaves the other unchanged.
- R10: After reset every address, prefetch and register word is zero, both addresses are unconfirmed and error signalling is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | APB_AW | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| pready | output | 1 | Always high, so there are no wait states |
| pslverr | output | 1 | Error response for a bad data access when enabled |

## Verification
The hardest state to reach is a confirmed address that software then silently loses. This can happen through a data or control access that lands between the two address writes, or through a third address write with a different value. On top of that, the prefetch register must be stale and not zero at the moment of the loss. The stimulus mixes random single and paired address writes, data and control accesses, and writes on the other channel. Directed sequences add the interrupted pair, masked upper address bits and an out-of-range address with errors enabled. A bench model built from the requirements predicts every read word and every PSLVERR.

// File: rtl/irb_pkg.sv
package irb_pkg;
  localparam int unsigned DW  = 32;
  localparam int unsigned IAW = 16;
  localparam int unsigned NCH = 2;

  typedef enum logic [1:0] {
    PORT_ADDR = 2'd0,
    PORT_DATA = 2'd1,
    PORT_CTRL = 2'd2,
    PORT_NONE = 2'd3
  } port_e;

  typedef struct packed {
    logic addr_wr;
    logic data_wr;
    logic data_rd;
    logic ctrl_wr;
    logic ctrl_rd;
  } chan_req_t;
endpackage

// File: rtl/irb_regfile.sv
module irb_regfile #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [IW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  // One register per word; the write enable picks the word.
  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mem_q[i] <= '0;
      else if (we && waddr == IW'(i))      mem_q[i] <= wdata;
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/irb_channel.sv
module irb_channel
  import irb_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  chan_req_t     req,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] addr_rd,
  output logic [DW-1:0] data_rd,
  output logic [DW-1:0] ctrl_rd,
  output logic          bad,
  output logic          err_en,
  output logic          confirmed,
  output logic [DW-1:0] pf
);
  localparam logic [IAW-1:0] LIMIT = IAW'(DEPTH);

  logic [IAW-1:0] stage_q, lat_q;
  logic           arm_q, cfm_q, en_q;
  logic [DW-1:0]  pf_q, rf_rdata;
  logic           in_range, touch;

  assign in_range = cfm_q && (lat_q < LIMIT);
  assign touch    = req.data_wr | req.data_rd | req.ctrl_wr | req.ctrl_rd;
  assign bad      = (req.data_wr | req.data_rd) & ~in_range;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      lat_q   <= '0;
      arm_q   <= 1'b0;
      cfm_q   <= 1'b0;
      en_q    <= 1'b0;
      pf_q    <= '0;
    end else begin
      if (req.addr_wr) begin
        // second equal write in a row confirms the address
        if (arm_q && stage_q == wdata[IAW-1:0]) begin
          cfm_q <= 1'b1;
          lat_q <= wdata[IAW-1:0];
        end else begin
          cfm_q <= 1'b0;
        end
        stage_q <= wdata[IAW-1:0];
        arm_q   <= 1'b1;
        pf_q    <= '0;
      end else if (touch) begin
        arm_q <= 1'b0;
      end
      if (req.data_rd) pf_q <= in_range ? rf_rdata : '0;
      if (req.ctrl_wr) en_q <= wdata[15];
    end
  end

  irb_regfile #(.DEPTH(DEPTH), .WIDTH(DW)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (req.data_wr & in_range),
    .waddr (lat_q[IW-1:0]),
    .wdata (wdata),
    .raddr (lat_q[IW-1:0]),
    .rdata (rf_rdata)
  );

  assign addr_rd   = {{(DW-IAW){1'b0}}, stage_q};
  assign data_rd   = pf_q;
  assign ctrl_rd   = {{(DW-16){1'b0}}, en_q, 15'b0};
  assign err_en    = en_q;
  assign confirmed = cfm_q;
  assign pf        = pf_q;
endmodule

// File: rtl/indirect_reg_bridge.sv
module indirect_reg_bridge
  import irb_pkg::*;
#(
  parameter int unsigned APB_AW = 8,
  parameter int unsigned DEPTH  = 16
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [APB_AW-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr
);
  logic        acc, hit;
  port_e       port;
  logic        unused_low;
  logic [NCH-1:0]         bad, en, cfm;
  logic [NCH-1:0][DW-1:0] pf_q, a_rd, d_rd, c_rd;

  assign acc        = psel & penable;
  assign hit        = (paddr[APB_AW-1:5] == '0);
  assign port       = port_e'(paddr[3:2]);
  assign unused_low = ^paddr[1:0];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    chan_req_t req;
    logic      sel;
    assign sel         = acc & hit & (paddr[4] == g[0]);
    assign req.addr_wr = sel &  pwrite & (port == PORT_ADDR);
    assign req.data_wr = sel &  pwrite & (port == PORT_DATA);
    assign req.data_rd = sel & ~pwrite & (port == PORT_DATA);
    assign req.ctrl_wr = sel &  pwrite & (port == PORT_CTRL);
    assign req.ctrl_rd = sel & ~pwrite & (port == PORT_CTRL);

    irb_channel #(.DEPTH(DEPTH)) u_ch (
      .clk       (pclk),
      .rst_n     (presetn),
      .req       (req),
      .wdata     (pwdata),
      .addr_rd   (a_rd[g]),
      .data_rd   (d_rd[g]),
      .ctrl_rd   (c_rd[g]),
      .bad       (bad[g]),
      .err_en    (en[g]),
      .confirmed (cfm[g]),
      .pf        (pf_q[g])
    );
  end

  always_comb begin
    prdata = '0;
    if (acc && hit && !pwrite) begin
      unique case (port)
        PORT_ADDR: prdata = a_rd[paddr[4]];
        PORT_DATA: prdata = d_rd[paddr[4]];
        PORT_CTRL: prdata = c_rd[paddr[4]];
        default:   prdata = '0;
      endcase
    end
  end

  assign pslverr = |(bad & en);
  assign pready  = 1'b1;
endmodule

// File: rtl/irb_checker.sv
module irb_checker #(
  parameter int unsigned APB_AW = 8
) (
  input logic                 pclk,
  input logic                 presetn,
  input logic                 psel,
  input logic                 penable,
  input logic                 pwrite,
  input logic [APB_AW-1:0]    paddr,
  input logic                 pslverr,
  input logic [1:0][31:0]     pf_q,
  input logic [1:0]           cfm
);
  logic acc;
  assign acc = psel & penable;

  // R8: errors only come from data-port accesses in the access phase
  a_r8_err_data_only: assert property (@(posedge pclk) disable iff (!presetn)
    pslverr |-> (acc && paddr[3:2] == 2'b01));

  // R5: an address-port write on channel 0 empties its prefetch
  a_r5_addr_clears_pf: assert property (@(posedge pclk) disable iff (!presetn)
    (acc && pwrite && paddr == '0) |=> (pf_q[0] == 32'd0));

  // R9: channel-1 traffic leaves channel 0 untouched
  a_r9_isolation: assert property (@(posedge pclk) disable iff (!presetn)
    (acc && paddr[4]) |=> ($stable(pf_q[0]) && $stable(cfm[0])));

  // R3: confirmation follows an address-port write on that channel
  a_r3_confirm_source: assert property (@(posedge pclk) disable iff (!presetn)
    $rose(cfm[1]) |-> $past(acc && pwrite && paddr == APB_AW'(8'h10)));
endmodule

bind indirect_reg_bridge irb_checker #(.APB_AW(APB_AW)) u_irb_checker (
  .pclk    (pclk),
  .presetn (presetn),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .pslverr (pslverr),
  .pf_q    (pf_q),
  .cfm     (cfm)
);

// File: tb/indirect_reg_bridge_bench.sv
module indirect_reg_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DEPTH = 16;

  logic pclk = 1'b0, presetn = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [AW-1:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, pslverr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [15:0] m_stage [2];
  logic [15:0] m_lat   [2];
  bit          m_arm [2], m_cfm [2], m_en [2];
  logic [31:0] m_pf [2];
  logic [31:0] m_mem [2][DEPTH];

  always #(CLK_PERIOD/2) pclk = ~pclk;

  indirect_reg_bridge #(.APB_AW(AW), .DEPTH(DEPTH)) u_indirect_reg_bridge (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit m_ok(input int c);
    return m_cfm[c] && (m_lat[c] < DEPTH);
  endfunction

  function automatic logic [AW-1:0] offs(input int c, input int p);
    return AW'(c * 16 + p * 4);
  endfunction

  task automatic apb(input logic wr, input logic [AW-1:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic err, output logic rdy);
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1;
    #1;
    rd = prdata; err = pslverr; rdy = pready;
    @(posedge pclk);
    #1;
    psel = 0; penable = 0;
  endtask

  task automatic addr_wr(input int c, input logic [31:0] v, input string req);
    logic [31:0] rd; logic err, rdy;
    apb(1, offs(c, 0), v, rd, err, rdy);
    check({req, " addr wr err"}, {31'b0, err}, 32'd0);
    if (m_arm[c] && m_stage[c] == v[15:0]) begin m_cfm[c] = 1; m_lat[c] = v[15:0]; end
    else m_cfm[c] = 0;
    m_stage[c] = v[15:0]; m_arm[c] = 1; m_pf[c] = '0;
  endtask

  task automatic data_rd(input int c, input string req);
    logic [31:0] rd; logic err, rdy;
    apb(0, offs(c, 1), '0, rd, err, rdy);
    check({req, " data rd"}, rd, m_pf[c]);
    check({req, " data rd err"}, {31'b0, err}, {31'b0, !m_ok(c) && m_en[c]});
    m_pf[c] = m_ok(c) ? m_mem[c][m_lat[c][3:0]] : '0;
    m_arm[c] = 0;
  endtask

  task automatic data_wr(input int c, input logic [31:0] v, input string req);
    logic [31:0] rd; logic err, rdy;
    apb(1, offs(c, 1), v, rd, err, rdy);
    check({req, " data wr err"}, {31'b0, err}, {31'b0, !m_ok(c) && m_en[c]});
    if (m_ok(c)) m_mem[c][m_lat[c][3:0]] = v;
    m_arm[c] = 0;
  endtask

  task automatic ctrl_wr(input int c, input logic [31:0] v);
    logic [31:0] rd; logic err, rdy;
    apb(1, offs(c, 2), v, rd, err, rdy);
    check("R8 ctrl wr err", {31'b0, err}, 32'd0);
    m_en[c] = v[15]; m_arm[c] = 0;
  endtask

  task automatic ctrl_rd(input int c, input string req);
    logic [31:0] rd; logic err, rdy;
    apb(0, offs(c, 2), '0, rd, err, rdy);
    check({req, " ctrl rd"}, rd, {16'b0, m_en[c], 15'b0});
    m_arm[c] = 0;
  endtask

  task automatic addr_rd(input int c, input string req);
    logic [31:0] rd; logic err, rdy;
    apb(0, offs(c, 0), '0, rd, err, rdy);
    check({req, " addr rd"}, rd, {16'b0, m_stage[c]});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd; logic err, rdy;
    void'($urandom(32'd2024));
    for (int c = 0; c < 2; c++) begin
      m_stage[c] = '0; m_lat[c] = '0; m_arm[c] = 0; m_cfm[c] = 0; m_en[c] = 0; m_pf[c] = '0;
      for (int i = 0; i < DEPTH; i++) m_mem[c][i] = '0;
    end
    repeat (3) @(posedge pclk);
    #1 presetn = 1;

    // R10 reset state
    addr_rd(0, "R10");
    ctrl_rd(1, "R10");
    data_rd(0, "R10");

    // R1 pready, unmapped offsets
    apb(1, 8'h0C, 32'hFFFF_FFFF, rd, err, rdy);
    check("R1 pready", {31'b0, rdy}, 32'd1);
    check("R1 unmapped wr err", {31'b0, err}, 32'd0);
    apb(0, 8'h0C, '0, rd, err, rdy);
    check("R1 unmapped rd", rd, 32'd0);
    apb(1, 8'h40, 32'h0000_8000, rd, err, rdy);
    ctrl_rd(0, "R1 high offset ignored");

    // R2 masking, R3 confirm, R5 stale zero, R6 write, R4 double read
    addr_wr(0, 32'hABCD_0003, "R2");
    addr_wr(0, 32'h1234_0003, "R3");
    addr_rd(0, "R2");
    data_wr(0, 32'hCAFE_0001, "R6");
    data_rd(0, "R5 first read zero");
    data_rd(0, "R4 second read word");
    addr_wr(1, 32'h5, "R9"); addr_wr(1, 32'h5, "R9");
    data_wr(1, 32'h0BAD_0001, "R9");
    data_rd(0, "R9 ch0 unaffected");

    // R3 interrupted pair stays unconfirmed, R8 error
    ctrl_wr(0, 32'h0000_8000);
    ctrl_rd(0, "R8");
    addr_wr(0, 32'h7, "R3");
    data_rd(0, "R3 interrupt");
    addr_wr(0, 32'h7, "R3");
    data_wr(0, 32'h1111_1111, "R3 unconfirmed err");
    addr_wr(0, 32'h7, "R3"); addr_wr(0, 32'h8, "R3");
    data_rd(0, "R3 differing value");

    // R7 out of range with errors on
    addr_wr(0, 32'h20, "R7"); addr_wr(0, 32'h20, "R7");
    data_wr(0, 32'hDEAD_BEEF, "R7");
    data_rd(0, "R7");
    data_rd(0, "R7 zero fetch");

    // random mix
    for (int it = 0; it < 600; it++) begin
      int c, op;
      logic [31:0] v;
      c  = int'($urandom % 2);
      op = int'($urandom % 8);
      v  = $urandom;
      if ($urandom % 4 != 0) v[15:0] = 16'($urandom % 20);
      case (op)
        0: addr_wr(c, v, "R3 rnd");
        1: begin addr_wr(c, v, "R3 rnd"); addr_wr(c, v, "R3 rnd"); end
        2, 3: data_rd(c, "R4 rnd");
        4: data_wr(c, v, "R6 rnd");
        5: ctrl_wr(c, v);
        6: ctrl_rd(c, "R8 rnd");
        default: addr_rd(c, "R2 rnd");
      endcase
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule